// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a logical address bypasses paging by landing inside one of a small set of transparent windows. The windows come in two equal groups: one group serves instruction fetches, the other serves data accesses. Each window is a 32-bit word that holds an enable flag, an 8-bit address base, an 8-bit don't-care mask, a privilege selector and a write-protect flag. When a window matches, the physical address equals the logical address. The block returns read, execute and write permissions, and it raises a fault pulse when a store targets a protected window.

A request presents an address, a code/data flag, a supervisor flag, a store flag and a probe flag. The response appears one clock later. A probe that hits loads a status word with two flags: transparent and resident. The window words are loaded through a single-word write port with a window index. Index values 0 to WIN_PER_SIDE-1 select instruction windows, and the following indices select data windows. A synchronous reset clears every window and the status word.

Top module: `ttw_matcher`

## Requirements
- R1: While `rst` is high at a clock edge, every window word and the status word are cleared to zero. After reset, no request hits and `probe_status` reads 0.
- R2: A window whose enable bit (bit 15) is 0 never matches, whatever its other fields hold.
- R3: The privilege selector is bits 14:13. Value 00 matches only when `req_super` is 0. Value 01 matches only when `req_super` is 1. Values 10 and 11 match in either mode.
- R4: A window matches only when address bits 31:24 equal base bits 31:24 at every position where mask bits 23:16 are 0. A mask bit of 1 makes that address bit a don't-care.
- R5: A request with `req_code`=1 tests only the instruction windows (indices 0 to WIN_PER_SIDE-1). A request with `req_code`=0 tests only the data windows (indices WIN_PER_SIDE and up).
- R6: When several windows of the tested group match, the one with the lowest index decides the permissions.
- R7: On a hit, `rsp_rd` and `rsp_ex` are 1, and `rsp_wr` is 1 only if the deciding window's write-protect bit (bit 2) is 0. On a miss, all three are 0.
- R8: On a hit, `rsp_phys` equals the request address. On a miss, it is 0.
- R9: A non-probe store that hits a write-protected window drives `rsp_fault` high for exactly the response cycle of that request. A probe, a load, or an unprotected hit gives no fault.
- R10: A probe request that hits sets `probe_status` to 0x00000003 (bit 1 transparent, bit 0 resident). A probe miss, and any non-probe request, leave `probe_status` unchanged.
- R11: All `rsp_*` outputs are registered. They reflect the request of the previous cycle. `rsp_valid` follows `req_valid` by one cycle, and all response fields are 0 when there was no request.
- R12: A write with `cfg_we`=1 replaces window `cfg_idx` at the clock edge. A request in the same cycle still sees the old contents, and a request in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Window word write strobe |
| cfg_idx | input | IDX_W | Window index to write |
| cfg_wdata | input | 32 | New window word |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Logical address |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_super | input | 1 | 1 = supervisor mode |
| req_store | input | 1 | 1 = store access |
| req_probe | input | 1 | 1 = probe, updates status on hit |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Address fell inside a window |
| rsp_phys | output | 32 | Physical address on hit, else 0 |
| rsp_rd | output | 1 | Read permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_fault | output | 1 | Store to a protected window |
| probe_status | output | 32 | Status word loaded by probe hits |

## Verification
The bench builds the block with the default WIN_PER_SIDE of 2, so there are four windows. With this setting, every window is reachable through the two-bit index, and the priority of two same-group windows can be exercised directly. A behavioural model holds its own copy of the window words and recomputes each response every clock. This exposes same-cycle write-versus-request ordering, overlapping windows of different protection, the privilege selector codes, and probe status retention across misses and a second reset.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
    localparam int WORD_W    = 32;
    localparam int FIELD_W   = 8;
    localparam int BASE_LSB  = 24;
    localparam int MASK_LSB  = 16;
    localparam int EN_BIT    = 15;
    localparam int PRIV_LSB  = 13;
    localparam int WP_BIT    = 2;
    localparam logic [1:0] PRIV_USER_ONLY  = 2'b00;
    localparam logic [1:0] PRIV_SUPER_ONLY = 2'b01;
    localparam int STAT_RES_BIT = 0;
    localparam int STAT_TT_BIT  = 1;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              rd;
        logic              ex;
        logic              wr;
        logic              fault;
        logic [WORD_W-1:0] phys;
        logic [WORD_W-1:0] status;
    } rsp_state_t;
endpackage

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp
    import ttw_pkg::*;
(
    input  logic [WORD_W-1:0]  win_i,
    input  logic [FIELD_W-1:0] addr_hi_i,
    input  logic               super_i,
    output logic               match_o,
    output logic               wp_o
);
    logic               en;
    logic [1:0]         priv;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] care;
    logic               priv_ok;
    logic               addr_ok;

    always_comb begin
        en   = win_i[EN_BIT];
        priv = win_i[PRIV_LSB +: 2];
        base = win_i[BASE_LSB +: FIELD_W];
        care = ~win_i[MASK_LSB +: FIELD_W];
        unique case (priv)
            PRIV_USER_ONLY:  priv_ok = ~super_i;
            PRIV_SUPER_ONLY: priv_ok = super_i;
            default:         priv_ok = 1'b1;
        endcase
        addr_ok = ((addr_hi_i ^ base) & care) == '0;
        match_o = en && priv_ok && addr_ok;
        wp_o    = win_i[WP_BIT];
    end
endmodule

// File: rtl/ttw_regfile.sv
module ttw_regfile
    import ttw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [WORD_W-1:0]              wdata_i,
    output logic [NUM_WIN-1:0][WORD_W-1:0] win_o
);
    logic [NUM_WIN-1:0][WORD_W-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (we_i) begin
            win_d[idx_i] = wdata_i;
        end
        if (rst) begin
            win_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        win_q <= win_d;
    end

    assign win_o = win_q;

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_rst_chk
            p_reset_clears_r1: assert property (@(posedge clk)
                rst |=> (win_q[g][EN_BIT] == 1'b0));
        end
    endgenerate

    p_write_lands_r12: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (win_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
    import ttw_pkg::*;
#(
    parameter int WIN_PER_SIDE = 2,
    localparam int NUM_WIN     = 2 * WIN_PER_SIDE,
    localparam int IDX_W       = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_code,
    input  logic              req_super,
    input  logic              req_store,
    input  logic              req_probe,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_phys,
    output logic              rsp_rd,
    output logic              rsp_ex,
    output logic              rsp_wr,
    output logic              rsp_fault,
    output logic [31:0]       probe_status
);
    logic [NUM_WIN-1:0][WORD_W-1:0] win;
    logic [NUM_WIN-1:0]             match;
    logic [NUM_WIN-1:0]             wp;
    logic [NUM_WIN-1:0]             sel;
    logic                           found;
    logic                           sel_wp;
    rsp_state_t                     r_d, r_q;

    ttw_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .idx_i   (cfg_idx),
        .wdata_i (cfg_wdata),
        .win_o   (win)
    );

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
            ttw_window_cmp u_cmp (
                .win_i     (win[g]),
                .addr_hi_i (req_addr[BASE_LSB +: FIELD_W]),
                .super_i   (req_super),
                .match_o   (match[g]),
                .wp_o      (wp[g])
            );
        end
    endgenerate

    // Priority pick inside the group chosen by the access kind.
    always_comb begin
        sel    = '0;
        found  = 1'b0;
        sel_wp = 1'b0;
        for (int k = 0; k < WIN_PER_SIDE; k++) begin
            int w;
            w = req_code ? k : WIN_PER_SIDE + k;
            if (!found && match[w]) begin
                found  = 1'b1;
                sel[w] = 1'b1;
                sel_wp = wp[w];
            end
        end
    end

    always_comb begin
        r_d        = r_q;
        r_d.valid  = req_valid;
        r_d.hit    = req_valid && found;
        r_d.rd     = r_d.hit;
        r_d.ex     = r_d.hit;
        r_d.wr     = r_d.hit && !sel_wp;
        r_d.fault  = r_d.hit && sel_wp && req_store && !req_probe;
        r_d.phys   = r_d.hit ? req_addr : '0;
        if (r_d.hit && req_probe) begin
            r_d.status               = '0;
            r_d.status[STAT_TT_BIT]  = 1'b1;
            r_d.status[STAT_RES_BIT] = 1'b1;
        end
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rsp_valid    = r_q.valid;
    assign rsp_hit      = r_q.hit;
    assign rsp_phys     = r_q.phys;
    assign rsp_rd       = r_q.rd;
    assign rsp_ex       = r_q.ex;
    assign rsp_wr       = r_q.wr;
    assign rsp_fault    = r_q.fault;
    assign probe_status = r_q.status;

    p_single_winner_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    p_read_exec_on_hit_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_rd && rsp_ex));
    p_phys_identity_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_phys == $past(req_addr)));
    p_fault_needs_protected_hit_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_hit && !rsp_wr));
    p_status_only_by_probe_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(probe_status) |-> $past(req_valid && req_probe));
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
endmodule

// File: tb/ttw_matcher_bench.sv
module ttw_matcher_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_code = 1'b0;
    logic        req_super = 1'b0;
    logic        req_store = 1'b0;
    logic        req_probe = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_rd, rsp_ex, rsp_wr, rsp_fault;
    logic [31:0] rsp_phys, probe_status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_win [4];
    logic [31:0] m_status;
    logic        e_valid, e_hit, e_rd, e_ex, e_wr, e_fault;
    logic [31:0] e_phys;

    always #10 clk = ~clk;

    ttw_matcher u_ttw_matcher (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_code(req_code),
        .req_super(req_super), .req_store(req_store), .req_probe(req_probe),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_phys(rsp_phys),
        .rsp_rd(rsp_rd), .rsp_ex(rsp_ex), .rsp_wr(rsp_wr), .rsp_fault(rsp_fault),
        .probe_status(probe_status)
    );

    function automatic logic [31:0] mkwin(bit en, logic [7:0] base, logic [7:0] dc,
                                          logic [1:0] priv, bit wp);
        logic [31:0] v;
        v = '0;
        v[31:24] = base;
        v[23:16] = dc;
        v[15]    = en;
        v[14:13] = priv;
        v[2]     = wp;
        return v;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic predict(bit rv, logic [31:0] a, bit code, bit sup, bit st, bit pr);
        bit found;
        bit prot;
        found = 0;
        prot  = 0;
        for (int k = 0; k < 2; k++) begin
            int w;
            logic [31:0] r;
            logic [7:0] care;
            w = code ? k : 2 + k;
            r = m_win[w];
            if (found || !r[15]) continue;
            if (r[14:13] == 2'b00 && sup) continue;
            if (r[14:13] == 2'b01 && !sup) continue;
            care = ~r[23:16];
            if ((a[31:24] & care) != (r[31:24] & care)) continue;
            found = 1;
            prot  = r[2];
        end
        e_valid = rv;
        e_hit   = rv && found;
        e_rd    = e_hit;
        e_ex    = e_hit;
        e_wr    = e_hit && !prot;
        e_fault = e_hit && prot && st && !pr;
        e_phys  = e_hit ? a : 32'h0;
        if (e_hit && pr) m_status = 32'h3;
    endtask

    task automatic compare_all(string tag);
        check(rsp_valid === e_valid, tag, "valid", {31'b0, rsp_valid}, {31'b0, e_valid});
        check(rsp_hit === e_hit, tag, "hit", {31'b0, rsp_hit}, {31'b0, e_hit});
        check(rsp_rd === e_rd, tag, "rd", {31'b0, rsp_rd}, {31'b0, e_rd});
        check(rsp_ex === e_ex, tag, "ex", {31'b0, rsp_ex}, {31'b0, e_ex});
        check(rsp_wr === e_wr, tag, "wr", {31'b0, rsp_wr}, {31'b0, e_wr});
        check(rsp_fault === e_fault, tag, "fault", {31'b0, rsp_fault}, {31'b0, e_fault});
        check(rsp_phys === e_phys, tag, "phys", rsp_phys, e_phys);
        check(probe_status === m_status, tag, "status", probe_status, m_status);
    endtask

    // One clock: drive at negedge, predict, update model at posedge, compare at next negedge.
    task automatic cyc(bit we, logic [1:0] idx, logic [31:0] wd, bit rv, logic [31:0] a,
                       bit code, bit sup, bit st, bit pr, string tag);
        cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
        req_valid = rv; req_addr = a; req_code = code;
        req_super = sup; req_store = st; req_probe = pr;
        predict(rv, a, code, sup, st, pr);
        @(posedge clk);
        if (we) m_win[idx] = wd;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic wr(logic [1:0] idx, logic [31:0] wd, string tag);
        cyc(1, idx, wd, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rq(logic [31:0] a, bit code, bit sup, bit st, bit pr, string tag);
        cyc(0, 0, 0, 1, a, code, sup, st, pr, tag);
    endtask

    task automatic do_reset();
        cfg_we = 0; req_valid = 0; req_probe = 0; req_store = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 4; i++) m_win[i] = '0;
        m_status = '0;
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: after reset nothing matches and status is clear
        rq(32'h4000_0000, 0, 1, 0, 0, "R1");
        rq(32'h0000_0000, 1, 0, 0, 0, "R1");
        // R12: write and request in the same cycle: old contents used
        cyc(1, 2, mkwin(1, 8'h40, 8'h00, 2'b10, 0), 1, 32'h4000_1234, 0, 0, 0, 0, "R12");
        // R8/R7: next cycle sees the new window
        rq(32'h4000_1234, 0, 0, 0, 0, "R8");
        rq(32'h40FF_FFFC, 0, 1, 1, 0, "R7");
        // R5: instruction group is still empty
        rq(32'h4000_1234, 1, 0, 0, 0, "R5");
        // R10: probe miss keeps status
        rq(32'h7700_0000, 1, 1, 0, 1, "R10");
        // R4: mask makes the low four base bits don't-care
        wr(0, mkwin(1, 8'h80, 8'h0F, 2'b11, 1), "R4");
        rq(32'h8A00_0010, 1, 0, 0, 0, "R4");
        rq(32'h8F12_3456, 1, 1, 0, 0, "R4");
        rq(32'h9A00_0000, 1, 0, 0, 0, "R4");
        rq(32'h8A00_0010, 0, 0, 0, 0, "R5");
        // R2: disabled window never matches
        wr(1, mkwin(0, 8'h12, 8'hFF, 2'b10, 0), "R2");
        rq(32'h1200_0000, 1, 0, 0, 0, "R2");
        rq(32'h5500_0000, 1, 1, 0, 0, "R2");
        // R3: privilege selector codes
        wr(3, mkwin(1, 8'h20, 8'h00, 2'b00, 0), "R3");
        rq(32'h2000_0008, 0, 1, 0, 0, "R3");
        rq(32'h2000_0008, 0, 0, 0, 0, "R3");
        wr(1, mkwin(1, 8'h30, 8'h00, 2'b01, 1), "R3");
        rq(32'h3000_0000, 1, 0, 0, 0, "R3");
        rq(32'h3000_0000, 1, 1, 0, 0, "R3");
        // R6: overlapping data windows, lower index wins
        wr(3, mkwin(1, 8'h00, 8'hFF, 2'b11, 1), "R6");
        rq(32'h4000_0000, 0, 0, 0, 0, "R6");
        rq(32'h4100_0000, 0, 1, 0, 0, "R6");
        // R9: protected store faults for one cycle only
        rq(32'h4100_0000, 0, 0, 1, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        rq(32'h4000_0000, 0, 0, 1, 0, "R9");
        rq(32'h4100_0000, 0, 0, 0, 0, "R9");
        // R10: probe hit sets status, probe store gives no fault
        rq(32'h5500_0000, 0, 1, 1, 1, "R10");
        rq(32'h3000_0000, 1, 0, 0, 1, "R10");
        rq(32'h4100_0000, 0, 0, 1, 0, "R10");
        // R11: idle cycles drop every response field
        cyc(0, 0, 0, 0, 32'h4000_0000, 0, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, 32'h4000_0000, 1, 1, 1, 1, "R11");
        // R1: reset again clears windows and status
        do_reset();
        rq(32'h4000_0000, 0, 0, 0, 0, "R1");
        rq(32'h8A00_0000, 1, 0, 0, 1, "R1");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule